// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block is a performance monitoring unit. It holds a bank of event counters that software reaches through a simple memory-mapped register port. Each counter watches one line of a wide event bus, and an 8-bit code per counter chooses the line. A counter advances by one in every cycle that its chosen line is high. It does so only while two enables are set: a single run bit that starts and stops the whole bank, and the counter's own enable bit.

A counter that wraps past its 48-bit maximum records an overflow in a status register. That status bit holds until software writes a one to its bit in a separate clear register. A per-counter mask decides whether a recorded overflow reaches the single level interrupt output. Software reads and writes counters as 64-bit values and all other registers as 32-bit values carried in the low half of the data bus. Reads are combinational from the address, and writes take effect on the clock edge that samples the write strobe.

Top module: `evcnt_unit`

## Requirements
- R1: After reset, all counters read 0, the enable register (0x1C00) reads 0, the control register (0x0408) reads 0, status (0x0808) reads 0, the mask (0x0800) reads 0xFF, both event select registers read 0xFFFFFFFF, and irq_o is low.
- R2: Counter n advances by exactly one on each clock edge where three conditions hold together: control bit 16 is 1, enable bit n is 1, and evt_in[code n] is high. The new value is readable right after that edge.
- R3: Clearing control bit 16, or clearing enable bit n, freezes counter n even while its event line is high.
- R4: Event code 0xFF selects no event. A counter holding that code never advances, even with evt_in[255] high.
- R5: Counter n takes its code from byte lane n mod 4, bits 8*(n mod 4)+7 down to 8*(n mod 4), of the select register at 0x1D00 + 4*(n div 4). Written values read back unchanged.
- R6: Counter n sits at 0x1E00 + 8*n as a 64-bit value. Bits 63:48 read as zero and ignore writes.
- R7: A software write to a counter on the same edge as an event increment loads the written value, and the increment is lost.
- R8: An increment from 0xFFFFFFFFFFFF wraps the counter to zero and sets status bit n on the same edge.
- R9: Writing 1 to bit n of 0x080C clears status bit n, and a 0 leaves it alone. If a wrap and a clear hit the same bit on the same edge, the bit ends set.
- R10: irq_o is high exactly while some status bit n is 1 and its mask bit n (0x0800) is 0. Status bits still record while masked.
- R11: Unmapped offsets read zero. Writes to the status register at 0x0808 have no effect. Control bits other than bit 16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 16 | Byte address of the register |
| bus_wdata_i | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_rdata_o | output | 64 | Combinational read data for bus_addr_i |
| evt_in_i | input | 256 | Event lines, one pulse per cycle per line |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Two pairs of functions can land on the same edge. In the first, a counter's event line stays high while software writes that counter. The bench reads back the written value right after the edge, which shows the increment was dropped, and then sees counting resume on the next edge. In the second, a counter is preloaded to its all-ones value so that its wrap edge coincides with a write-one-to-clear of the same status bit. Status must read as set afterwards, and with the mask bit open the interrupt must be high.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   localparam int OFS_CTRL   = 'h0408;
   localparam int OFS_MASK   = 'h0800;
   localparam int OFS_STAT   = 'h0808;
   localparam int OFS_CLR    = 'h080C;
   localparam int OFS_ENA    = 'h1C00;
   localparam int OFS_SEL    = 'h1D00;
   localparam int OFS_CNT    = 'h1E00;
   localparam int RUN_BIT    = 16;
   localparam int LANE_W     = 8;
   localparam int LANES      = 4;
   localparam int CNT_STRIDE = 8;
   localparam int SEL_STRIDE = 4;
endpackage

// File: rtl/evcnt_sel.sv
module evcnt_sel #(
   parameter int CODE_W = 8,
   localparam int NUM_EVT = 1 << CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              hit_o
);
   localparam logic [CODE_W-1:0] CODE_NONE = '1;

   always_comb begin
      hit_o = (code_i != CODE_NONE) && evt_i[code_i];
   end

   // R4: the reserved code never produces a hit
   assert_none_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i == CODE_NONE) |-> !hit_o);
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
   parameter int CNT_W = 48
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      wrap_o = inc_i && !wr_i && (cnt_q == CNT_MAX);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (wr_i)   cnt_q <= wdata_i;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_i) |=> $stable(cnt_q));
   assert_wr_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (cnt_q == $past(wdata_i)));
   assert_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/evcnt_ovf.sv
module evcnt_ovf #(
   parameter int NUM_CNT = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CNT-1:0] set_i,
   input  logic [NUM_CNT-1:0] clr_i,
   input  logic [NUM_CNT-1:0] mask_i,
   output logic [NUM_CNT-1:0] st_o,
   output logic               irq_o
);
   logic [NUM_CNT-1:0] st_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= (st_q & ~clr_i) | set_i;
   end

   always_comb begin
      irq_o = |(st_q & ~mask_i);
   end

   assign st_o = st_q;

   assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));
   assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_i & ~set_i)) |=> ((st_q & $past(clr_i & ~set_i)) == '0));
   assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask_i) |-> !irq_o);
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
   import evcnt_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 48,
   parameter int CODE_W  = 8,
   parameter int ADDR_W  = 16,
   localparam int NUM_EVT = 1 << CODE_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [63:0]        bus_wdata_i,
   output logic [63:0]        bus_rdata_o,
   input  logic [NUM_EVT-1:0] evt_in_i,
   output logic               irq_o
);
   localparam int NUM_SEL = (NUM_CNT + LANES - 1) / LANES;

   if (NUM_CNT < 1 || NUM_CNT > 32) begin : g_bad_cnt
      $error("NUM_CNT must be within 1..32");
   end
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_w
      $error("CNT_W must be within 2..64");
   end
   if (CODE_W < 1 || CODE_W > LANE_W) begin : g_bad_code
      $error("CODE_W must fit one byte lane");
   end

   logic               run_q;
   logic [NUM_CNT-1:0] ena_q;
   logic [NUM_CNT-1:0] mask_q;
   logic [CODE_W-1:0]  code_q [NUM_CNT];
   logic [CNT_W-1:0]   cnt_w  [NUM_CNT];
   logic [NUM_CNT-1:0] hit_w, inc_w, wrap_w, cwr_w, st_w, clr_w;

   logic wr_ctrl, wr_mask, wr_ena, wr_clr;
   always_comb begin
      wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CTRL));
      wr_mask = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK));
      wr_ena  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ENA));
      wr_clr  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CLR));
      clr_w   = wr_clr ? bus_wdata_i[NUM_CNT-1:0] : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         ena_q  <= '0;
         mask_q <= '1;
      end else begin
         if (wr_ctrl) run_q  <= bus_wdata_i[RUN_BIT];
         if (wr_ena)  ena_q  <= bus_wdata_i[NUM_CNT-1:0];
         if (wr_mask) mask_q <= bus_wdata_i[NUM_CNT-1:0];
      end
   end

   for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
      localparam int SEL_IDX = n / LANES;
      localparam int LANE    = n % LANES;
      localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(OFS_SEL + SEL_STRIDE * SEL_IDX);
      localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(OFS_CNT + CNT_STRIDE * n);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            code_q[n] <= '1;
         else if (bus_wr_i && (bus_addr_i == SEL_ADDR))
            code_q[n] <= bus_wdata_i[LANE_W*LANE +: CODE_W];
      end

      evcnt_sel #(.CODE_W(CODE_W)) u_sel (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .evt_i  (evt_in_i),
         .code_i (code_q[n]),
         .hit_o  (hit_w[n])
      );

      always_comb begin
         inc_w[n] = run_q && ena_q[n] && hit_w[n];
         cwr_w[n] = bus_wr_i && (bus_addr_i == CNT_ADDR);
      end

      evcnt_slice #(.CNT_W(CNT_W)) u_slice (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .inc_i   (inc_w[n]),
         .wr_i    (cwr_w[n]),
         .wdata_i (bus_wdata_i[CNT_W-1:0]),
         .cnt_o   (cnt_w[n]),
         .wrap_o  (wrap_w[n])
      );

      // R3: with the bank stopped, no counter may move on its own
      assert_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!run_q && !cwr_w[n]) |=> $stable(cnt_w[n]));
   end

   evcnt_ovf #(.NUM_CNT(NUM_CNT)) u_ovf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wrap_w),
      .clr_i  (clr_w),
      .mask_i (mask_q),
      .st_o   (st_w),
      .irq_o  (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(OFS_CTRL)) bus_rdata_o[RUN_BIT]     = run_q;
      if (bus_addr_i == ADDR_W'(OFS_MASK)) bus_rdata_o[NUM_CNT-1:0] = mask_q;
      if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o[NUM_CNT-1:0] = st_w;
      if (bus_addr_i == ADDR_W'(OFS_ENA))  bus_rdata_o[NUM_CNT-1:0] = ena_q;
      for (int k = 0; k < NUM_SEL; k++) begin
         if (bus_addr_i == ADDR_W'(OFS_SEL + SEL_STRIDE * k)) begin
            for (int l = 0; l < LANES; l++) begin
               if (k * LANES + l < NUM_CNT)
                  bus_rdata_o[LANE_W*l +: CODE_W] = code_q[k * LANES + l];
            end
         end
      end
      for (int n = 0; n < NUM_CNT; n++) begin
         if (bus_addr_i == ADDR_W'(OFS_CNT + CNT_STRIDE * n))
            bus_rdata_o = 64'(cnt_w[n]);
      end
   end

   // R10: an unmasked recorded overflow must drive the interrupt
   assert_irq_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(st_w & ~mask_q)) |-> irq_o);
endmodule

// File: tb/evcnt_unit_test.sv
module evcnt_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr = 1'b0;
   logic [15:0]  addr = '0;
   logic [63:0]  wdata = '0;
   logic [63:0]  rdata;
   logic [255:0] evt = '0;
   logic         irq;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           done = 0;

   always #4 clk = ~clk;

   evcnt_unit uut (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_in_i(evt), .irq_o(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [15:0] a, input logic [63:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp);
   endtask

   task automatic pulse(input int line, input int cycles);
      @(negedge clk);
      evt[line] = 1'b1;
      repeat (cycles) @(negedge clk);
      evt[line] = 1'b0;
   endtask

   task automatic t_reset;
      rchk("R1 ctrl", 16'h0408, 64'h0);
      rchk("R1 enable", 16'h1C00, 64'h0);
      rchk("R1 status", 16'h0808, 64'h0);
      rchk("R1 mask", 16'h0800, 64'hFF);
      rchk("R1 sel0", 16'h1D00, 64'hFFFF_FFFF);
      rchk("R1 sel1", 16'h1D04, 64'hFFFF_FFFF);
      for (int i = 0; i < 8; i++) rchk("R1 counter", 16'(16'h1E00 + 8 * i), 64'h0);
      check("R1 irq", 64'(irq), 64'h0);
   endtask

   task automatic t_count;
      wreg(16'h1D00, 64'hFFFF_FF05);
      wreg(16'h0408, 64'h0001_0000);
      wreg(16'h1C00, 64'h01);
      pulse(5, 3);
      rchk("R2 counter0 after 3 events", 16'h1E00, 64'd3);
      rchk("R2 counter1 untouched", 16'h1E08, 64'd0);
   endtask

   task automatic t_gate;
      wreg(16'h0408, 64'h0);
      pulse(5, 4);
      rchk("R3 run cleared", 16'h1E00, 64'd3);
      wreg(16'h0408, 64'h0001_0000);
      wreg(16'h1C00, 64'h0);
      pulse(5, 4);
      rchk("R3 enable cleared", 16'h1E00, 64'd3);
   endtask

   task automatic t_none;
      wreg(16'h1C00, 64'h02);
      pulse(255, 3);
      rchk("R4 code 0xFF idle", 16'h1E08, 64'd0);
   endtask

   task automatic t_select;
      wreg(16'h1D04, 64'h4433_2211);
      rchk("R5 sel1 readback", 16'h1D04, 64'h4433_2211);
      wreg(16'h1C00, 64'h40);
      @(negedge clk);
      evt[8'h33] = 1'b1; evt[8'h22] = 1'b1;
      repeat (2) @(negedge clk);
      evt[8'h33] = 1'b0; evt[8'h22] = 1'b0;
      rchk("R5 counter6 lane2", 16'h1E30, 64'd2);
      rchk("R5 counter5 disabled", 16'h1E28, 64'd0);
   endtask

   task automatic t_cntreg;
      wreg(16'h1E18, 64'hABCD_0000_1234_5678);
      rchk("R6 upper bits zero", 16'h1E18, 64'h0000_0000_1234_5678);
   endtask

   task automatic t_prio;
      @(negedge clk);
      evt[8'h33] = 1'b1;
      wr = 1'b1; addr = 16'h1E30; wdata = 64'd100;
      @(negedge clk);
      wr = 1'b0;
      rchk("R7 write beats increment", 16'h1E30, 64'd100);
      @(negedge clk);
      evt[8'h33] = 1'b0;
      rchk("R2 counting resumes", 16'h1E30, 64'd101);
   endtask

   task automatic t_wrap;
      wreg(16'h1D00, 64'hFF10_FF05);
      wreg(16'h1E10, 64'h0000_FFFF_FFFF_FFFE);
      wreg(16'h1C00, 64'h04);
      pulse(8'h10, 1);
      rchk("R8 at max no status", 16'h1E10, 64'h0000_FFFF_FFFF_FFFF);
      rchk("R8 status before wrap", 16'h0808, 64'h0);
      pulse(8'h10, 1);
      rchk("R8 wrapped to zero", 16'h1E10, 64'h0);
      rchk("R8 status bit2", 16'h0808, 64'h04);
      check("R10 masked irq low", 64'(irq), 64'h0);
      wreg(16'h0800, 64'hFB);
      #1;
      check("R10 unmasked irq high", 64'(irq), 64'h1);
      wreg(16'h080C, 64'h0);
      rchk("R9 clear with zero", 16'h0808, 64'h04);
      wreg(16'h080C, 64'h04);
      rchk("R9 clear with one", 16'h0808, 64'h0);
      check("R10 irq drops", 64'(irq), 64'h0);
   endtask

   task automatic t_collide;
      wreg(16'h1E10, 64'h0000_FFFF_FFFF_FFFF);
      @(negedge clk);
      evt[8'h10] = 1'b1;
      wr = 1'b1; addr = 16'h080C; wdata = 64'h04;
      @(negedge clk);
      wr = 1'b0; evt[8'h10] = 1'b0;
      rchk("R9 set beats clear", 16'h0808, 64'h04);
      check("R10 irq after collision", 64'(irq), 64'h1);
      wreg(16'h080C, 64'h04);
   endtask

   task automatic t_unmapped;
      rchk("R11 unmapped low", 16'h0004, 64'h0);
      rchk("R11 past last counter", 16'h1E40, 64'h0);
      wreg(16'h0808, 64'hFF);
      rchk("R11 status not writable", 16'h0808, 64'h0);
      wreg(16'h0408, 64'hFFFF_FFFF);
      rchk("R11 ctrl other bits", 16'h0408, 64'h0001_0000);
   endtask

   initial begin
      #2;
      check("R1 irq in reset", 64'(irq), 64'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_gate();
      t_none();
      t_select();
      t_cntreg();
      t_prio();
      t_wrap();
      t_collide();
      t_unmapped();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule